// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits between the processor-side bus and a PCI host bridge. It decides whether each processor memory access should be forwarded to PCI memory space. The top 256 MiB of the 32-bit space, starting at 0xF0000000, is split into thirty-two 8 MiB chunks. Chunk i starts at 0xF0000000 + i * 0x800000. Software can open any of chunks 1 to 30 as forwarding windows by setting the matching bit of a window-enable bitmap. Chunk 0 holds firmware and chunk 31 holds the bridge's own registers, so those two can never be opened. All forwarding is also gated by a two-bit mode field in a control register.

The same block steers inbound bus-master addresses coming from PCI. An address below 0xF0800000 goes to system memory. An address in the 31 chunks from 0xF0800000 upward goes to PCI memory. The address is passed through unchanged in both cases.

The two registers are written over a simple register bus and read back over a combinational read port. Both lookup paths are purely combinational and never stall. A request carries a valid bit, and its result belongs to the same cycle. No ready signal exists, because the decoder always accepts; back-pressure is the job of the surrounding bus.

Top module: `owd_window_decoder`

## Requirements
- R1: With forwarding mode on and enable bit i set (1 <= i <= 30), a valid access in chunk i (any offset 0..0x7FFFFF) asserts `ob_fwd`, and `ob_chunk` equals i.
- R2: Accesses to chunk 0 (0xF0000000..0xF07FFFFF) and chunk 31 (0xFF800000..0xFFFFFFFF) are never forwarded, and a cleared enable bit leaves its chunk unforwarded.
- R3: A write to the window-enable register (offset 0x060) stores the data ANDed with 0x7FFFFFFE, so bits 0 and 31 read back as zero.
- R4: Forwarding happens only when control register (offset 0x038) bits [8:7] equal 2'b01; the values 00, 10 and 11 forward nothing.
- R5: An access outside 0xF0000000..0xFFFFFFFF, or one whose `ob_valid` is low, is never forwarded.
- R6: A valid inbound address below 0xF0800000 gives `ib_tgt` = 0 (system memory).
- R7: A valid inbound address from 0xF0800000 to 0xFFFFFFFF gives `ib_tgt` = 1 (PCI memory). `ib_addr_out` always equals `ib_addr`, and `ib_tgt` = 2 (none) when `ib_valid` is low.
- R8: A register write changes the decode only from the cycle after the write; an access in the write cycle sees the old settings.
- R9: After reset both registers read zero and nothing is forwarded.
- R10: The control register keeps all 32 written bits. Reads of any other offset return zero, and writes to any other offset change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 12 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| ob_valid | input | 1 | Processor access present |
| ob_addr | input | 32 | Processor access address |
| ob_fwd | output | 1 | Access is claimed and forwarded to PCI |
| ob_chunk | output | 5 | Chunk index of the access |
| ib_valid | input | 1 | Inbound bus-master access present |
| ib_addr | input | 32 | Inbound address |
| ib_tgt | output | 2 | Inbound target: 0 system, 1 PCI, 2 none |
| ib_addr_out | output | 32 | Inbound address, passed through |

## Verification
Corrupt state here lives in only two registers, and it shows at the ports within one cycle. A wrong mask, or a wrong bit in the window bitmap, makes `ob_fwd` wrong for exactly the affected chunk. A wrong mode field makes it wrong for every chunk at once. The read port exposes both registers directly. Because the decode is combinational, a write that lands one cycle early or late is caught by sampling in the write cycle and again in the cycle after it.

// File: rtl/owd_pkg.sv
package owd_pkg;
  typedef enum logic [1:0] {
    TGT_SYS  = 2'd0,
    TGT_PCI  = 2'd1,
    TGT_NONE = 2'd2
  } tgt_e;

  localparam logic [1:0] MODE_FWD = 2'b01;
endpackage

// File: rtl/owd_regs.sv
module owd_regs
  import owd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 12,
  parameter int NUM_CHUNKS = 32,
  parameter int FIRST_FWD  = 1,
  parameter int LAST_FWD   = 30,
  parameter int MODE_LSB   = 7,
  parameter logic [OFS_W-1:0] CTRL_OFS = 12'h038,
  parameter logic [OFS_W-1:0] WEN_OFS  = 12'h060
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [OFS_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [OFS_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic [DATA_W-1:0]     ctrl_q,
  output logic [NUM_CHUNKS-1:0] wen_q,
  output logic                  fwd_on
);
  logic [NUM_CHUNKS-1:0] wen_mask;

  // chunks outside the forwardable span are tied off in the mask
  for (genvar i = 0; i < NUM_CHUNKS; i++) begin : g_mask
    assign wen_mask[i] = (i >= FIRST_FWD) && (i <= LAST_FWD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      wen_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == CTRL_OFS) ctrl_q <= wr_data;
      if (wr_addr == WEN_OFS)  wen_q  <= wr_data[NUM_CHUNKS-1:0] & wen_mask;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_OFS)     rd_data = ctrl_q;
    else if (rd_addr == WEN_OFS) rd_data[NUM_CHUNKS-1:0] = wen_q;
  end

  assign fwd_on = (ctrl_q[MODE_LSB+1:MODE_LSB] == MODE_FWD);
endmodule

// File: rtl/owd_out_decode.sv
module owd_out_decode #(
  parameter int ADDR_W  = 32,
  parameter int CHUNK_W = 23,
  parameter int IDX_W   = 5,
  parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000
) (
  input  logic                  valid,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  fwd_on,
  input  logic [(1<<IDX_W)-1:0] wen,
  output logic                  fwd,
  output logic [IDX_W-1:0]      chunk
);
  localparam int TAG_LSB = CHUNK_W + IDX_W;

  logic in_region;

  assign in_region = (addr[ADDR_W-1:TAG_LSB] == BASE[ADDR_W-1:TAG_LSB]);
  assign chunk     = addr[TAG_LSB-1:CHUNK_W];
  assign fwd       = valid & fwd_on & in_region & wen[chunk];
endmodule

// File: rtl/owd_in_steer.sv
module owd_in_steer
  import owd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CHUNK_W   = 23,
  parameter int FIRST_FWD = 1,
  parameter int IB_CHUNKS = 31,
  parameter logic [ADDR_W-1:0] BASE = 32'hF000_0000
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(1) << CHUNK_W;
  localparam logic [ADDR_W:0] LO   = {1'b0, BASE} + (ADDR_W+1)'(FIRST_FWD) * STEP;
  localparam logic [ADDR_W:0] HI   = LO + (ADDR_W+1)'(IB_CHUNKS) * STEP;

  logic [ADDR_W:0] wide;

  assign wide     = {1'b0, addr};
  assign addr_out = addr;

  always_comb begin
    if (!valid)         tgt = TGT_NONE;
    else if (wide < LO) tgt = TGT_SYS;
    else if (wide < HI) tgt = TGT_PCI;
    else                tgt = TGT_NONE;
  end
endmodule

// File: rtl/owd_window_decoder.sv
module owd_window_decoder
  import owd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int OFS_W       = 12,
  parameter int CHUNK_W     = 23,
  parameter int IDX_W       = 5,
  parameter int FIRST_FWD   = 1,
  parameter int LAST_FWD    = 30,
  parameter int IB_CHUNKS   = 31,
  parameter int MODE_LSB    = 7,
  parameter logic [ADDR_W-1:0] BASE     = 32'hF000_0000,
  parameter logic [OFS_W-1:0]  CTRL_OFS = 12'h038,
  parameter logic [OFS_W-1:0]  WEN_OFS  = 12'h060
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [OFS_W-1:0]  reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [OFS_W-1:0]  reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              ob_valid,
  input  logic [ADDR_W-1:0] ob_addr,
  output logic              ob_fwd,
  output logic [IDX_W-1:0]  ob_chunk,
  input  logic              ib_valid,
  input  logic [ADDR_W-1:0] ib_addr,
  output logic [1:0]        ib_tgt,
  output logic [ADDR_W-1:0] ib_addr_out
);
  localparam int NUM_CHUNKS = 1 << IDX_W;

  logic [DATA_W-1:0]     ctrl_q;
  logic [NUM_CHUNKS-1:0] wen_q;
  logic                  fwd_on;
  tgt_e                  ib_tgt_e;

  owd_regs #(
    .DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_CHUNKS(NUM_CHUNKS),
    .FIRST_FWD(FIRST_FWD), .LAST_FWD(LAST_FWD), .MODE_LSB(MODE_LSB),
    .CTRL_OFS(CTRL_OFS), .WEN_OFS(WEN_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .ctrl_q(ctrl_q), .wen_q(wen_q), .fwd_on(fwd_on)
  );

  owd_out_decode #(
    .ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W), .IDX_W(IDX_W), .BASE(BASE)
  ) u_out (
    .valid(ob_valid), .addr(ob_addr), .fwd_on(fwd_on), .wen(wen_q),
    .fwd(ob_fwd), .chunk(ob_chunk)
  );

  owd_in_steer #(
    .ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W), .FIRST_FWD(FIRST_FWD),
    .IB_CHUNKS(IB_CHUNKS), .BASE(BASE)
  ) u_in (
    .valid(ib_valid), .addr(ib_addr), .tgt(ib_tgt_e), .addr_out(ib_addr_out)
  );

  assign ib_tgt = ib_tgt_e;
endmodule

// File: rtl/owd_checker.sv
module owd_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int OFS_W      = 12,
  parameter int NUM_CHUNKS = 32,
  parameter int FIRST_FWD  = 1,
  parameter int LAST_FWD   = 30,
  parameter int CHUNK_W    = 23,
  parameter int MODE_LSB   = 7,
  parameter logic [ADDR_W-1:0] BASE    = 32'hF000_0000,
  parameter logic [OFS_W-1:0]  WEN_OFS = 12'h060
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr_en,
  input logic [OFS_W-1:0]      reg_wr_addr,
  input logic [DATA_W-1:0]     reg_wr_data,
  input logic [OFS_W-1:0]      reg_rd_addr,
  input logic [DATA_W-1:0]     reg_rd_data,
  input logic                  ob_valid,
  input logic [ADDR_W-1:0]     ob_addr,
  input logic                  ob_fwd,
  input logic                  ib_valid,
  input logic [ADDR_W-1:0]     ib_addr,
  input logic [1:0]            ib_tgt,
  input logic [ADDR_W-1:0]     ib_addr_out,
  input logic [DATA_W-1:0]     ctrl_q,
  input logic [NUM_CHUNKS-1:0] wen_q
);
  localparam logic [ADDR_W:0] STEP   = (ADDR_W+1)'(1) << CHUNK_W;
  localparam logic [ADDR_W:0] FWD_LO = {1'b0, BASE} + (ADDR_W+1)'(FIRST_FWD) * STEP;
  localparam logic [ADDR_W:0] FWD_HI = {1'b0, BASE} + (ADDR_W+1)'(LAST_FWD + 1) * STEP;

  function automatic logic [NUM_CHUNKS-1:0] legal_mask();
    logic [NUM_CHUNKS-1:0] m;
    m = '0;
    for (int i = FIRST_FWD; i <= LAST_FWD; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [NUM_CHUNKS-1:0] MASK = legal_mask();

  AST_FWD_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ob_fwd |-> ({1'b0, ob_addr} >= FWD_LO && {1'b0, ob_addr} < FWD_HI)); // R2

  AST_FWD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ob_fwd |-> (ctrl_q[MODE_LSB+1:MODE_LSB] == 2'b01)); // R4

  AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_valid |-> !ob_fwd); // R5

  AST_WEN_EDGES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_addr == WEN_OFS) |-> (reg_rd_data[0] == 1'b0 && reg_rd_data[NUM_CHUNKS-1] == 1'b0)); // R3

  AST_WEN_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == WEN_OFS) |=> (wen_q == ($past(reg_wr_data[NUM_CHUNKS-1:0]) & MASK))); // R8

  AST_IB_LOW_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && {1'b0, ib_addr} < FWD_LO) |-> (ib_tgt == 2'd0)); // R6

  AST_IB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ib_addr_out == ib_addr); // R7
endmodule

bind owd_window_decoder owd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_CHUNKS(1 << IDX_W),
  .FIRST_FWD(FIRST_FWD), .LAST_FWD(LAST_FWD), .CHUNK_W(CHUNK_W),
  .MODE_LSB(MODE_LSB), .BASE(BASE), .WEN_OFS(WEN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
  .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
  .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_fwd(ob_fwd),
  .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_tgt(ib_tgt), .ib_addr_out(ib_addr_out),
  .ctrl_q(ctrl_q), .wen_q(wen_q)
);

// File: tb/owd_window_decoder_tb.sv
`timescale 1ns/1ps
module owd_window_decoder_tb;
  localparam logic [11:0] CTRL = 12'h038;
  localparam logic [11:0] WEN  = 12'h060;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [11:0] reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        ob_valid = 1'b0;
  logic [31:0] ob_addr = '0;
  logic        ob_fwd;
  logic [4:0]  ob_chunk;
  logic        ib_valid = 1'b0;
  logic [31:0] ib_addr = '0;
  logic [1:0]  ib_tgt;
  logic [31:0] ib_addr_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  owd_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_fwd(ob_fwd), .ob_chunk(ob_chunk),
    .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_tgt(ib_tgt), .ib_addr_out(ib_addr_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_rd_addr = a;
    #1;
    chk(req, reg_rd_data, exp);
  endtask

  task automatic ob_chk(input string req, input logic v, input logic [31:0] a, input logic exp);
    ob_valid = v; ob_addr = a;
    #1;
    chk(req, {31'd0, ob_fwd}, {31'd0, exp});
    if (exp) chk(req, {27'd0, ob_chunk}, {27'd0, a[27:23]});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] a;
    logic [31:0] offs [3];
    offs[0] = 32'h0; offs[1] = 32'h0040_0000; offs[2] = 32'h007F_FFFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    rd_chk("R9 ctrl reset", CTRL, 32'h0);
    rd_chk("R9 wen reset", WEN, 32'h0);
    ob_chk("R9 no fwd at reset", 1'b1, 32'hF280_0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    ob_chk("R9 no fwd after reset", 1'b1, 32'hF280_0000, 1'b0);

    // R3: mask on enable write
    wr(WEN, 32'hFFFF_FFFF);
    rd_chk("R3 wen masked", WEN, 32'h7FFF_FFFE);
    // R10: control keeps all bits
    wr(CTRL, 32'hA5A5_5AC3);
    rd_chk("R10 ctrl readback", CTRL, 32'hA5A5_5AC3);
    wr(12'h044, 32'h1234_5678);
    rd_chk("R10 other offset reads 0", 12'h044, 32'h0);
    rd_chk("R10 ctrl unchanged", CTRL, 32'hA5A5_5AC3);
    rd_chk("R10 wen unchanged", WEN, 32'h7FFF_FFFE);

    // R1 R2 R4: every mode, every chunk, three offsets, all windows open
    for (int m = 0; m < 4; m++) begin
      wr(CTRL, 32'hFFFF_FE7F | (32'(m) << 7));
      for (int c = 0; c < 32; c++) begin
        for (int o = 0; o < 3; o++) begin
          a = 32'hF000_0000 + 32'(c) * 32'h0080_0000 + offs[o];
          ob_chk((m == 1) ? "R1 R2 chunk sweep" : "R4 mode gates",
                 1'b1, a, (m == 1) && (c >= 1) && (c <= 30));
        end
      end
    end

    // R1 R2: walking one over the enable bitmap, mode on
    wr(CTRL, 32'h0000_0080);
    for (int b = 0; b < 32; b++) begin
      wr(WEN, 32'h1 << b);
      rd_chk("R3 walk readback", WEN, (b >= 1 && b <= 30) ? (32'h1 << b) : 32'h0);
      for (int c = 0; c < 32; c++) begin
        a = 32'hF000_0000 + 32'(c) * 32'h0080_0000 + 32'h0000_1000;
        ob_chk("R2 walking enable", 1'b1, a, (c == b) && (b >= 1) && (b <= 30));
      end
    end

    // R5: outside region and invalid
    wr(WEN, 32'hFFFF_FFFF);
    ob_chk("R5 low addr", 1'b1, 32'h0000_0000, 1'b0);
    ob_chk("R5 below base", 1'b1, 32'hEFFF_FFFF, 1'b0);
    ob_chk("R5 alias upper", 1'b1, 32'h7280_0000, 1'b0);
    ob_chk("R5 alias upper 2", 1'b1, 32'hE280_0000, 1'b0);
    ob_chk("R5 valid low", 1'b0, 32'hF280_0000, 1'b0);
    ob_chk("R1 valid high", 1'b1, 32'hF280_0000, 1'b1);

    // R8: same-cycle write sees old settings
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = WEN; reg_wr_data = 32'h0;
    ob_chk("R8 old enable in write cycle", 1'b1, 32'hF500_0000, 1'b1);
    @(negedge clk);
    reg_wr_en = 1'b0;
    ob_chk("R8 new enable next cycle", 1'b1, 32'hF500_0000, 1'b0);
    wr(WEN, 32'h0000_0400);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = CTRL; reg_wr_data = 32'h0000_0100;
    ob_chk("R8 old mode in write cycle", 1'b1, 32'hF500_0000, 1'b1);
    @(negedge clk);
    reg_wr_en = 1'b0;
    ob_chk("R8 new mode next cycle", 1'b1, 32'hF500_0000, 1'b0);
    ob_valid = 1'b0;

    // R6 R7: inbound steering
    ib_valid = 1'b1;
    for (int k = 0; k < 40; k++) begin
      a = (k < 32) ? 32'(k) * 32'h0800_0000 + 32'h0000_0010
                   : 32'hF07F_FFF8 + 32'(k - 32);
      ib_addr = a;
      #1;
      chk((a < 32'hF080_0000) ? "R6 inbound sys" : "R7 inbound pci",
          {30'd0, ib_tgt}, (a < 32'hF080_0000) ? 32'd0 : 32'd1);
      chk("R7 addr pass", ib_addr_out, a);
    end
    ib_addr = 32'hFFFF_FFFF; #1;
    chk("R7 top address pci", {30'd0, ib_tgt}, 32'd1);
    ib_valid = 1'b0; #1;
    chk("R7 invalid none", {30'd0, ib_tgt}, 32'd2);
    chk("R7 addr pass invalid", ib_addr_out, 32'hFFFF_FFFF);

    finish_run();
  end
endmodule